// File: doc/BRIEF.md
# Linked Command Chain Walker

This block follows a chain of command nodes stored in system memory and feeds their payload to a downstream command framer. Each node is a header word followed by zero or more payload words. The header gives the number of payload words and the address of the following node. The walker fetches the header, then reads the payload words from the consecutive words after it and hands each one to the framer. It then moves on to the next node. The walk stops when the next address carries the end marker.

While it walks, the block publishes the address it will visit next after every node. It also keeps a running estimate of the processing cost. It guards against chains that loop back on themselves by comparing each next address with a saved checkpoint. The checkpoint is refreshed at node counts that double each time, so every cycle in a chain is caught sooner or later. A caught loop ends the walk with a sticky error. Memory is reached through a plain request/response port: the request and its address are held until a response is returned.

The state machine has six states. ST_IDLE waits for start. ST_HDR requests the header. ST_PAY requests one payload word. ST_OUT offers that word to the framer. ST_NEXT publishes progress and runs the loop check. ST_DONE emits the completion pulse. The transitions are:
- ST_IDLE to ST_HDR on start.
- ST_IDLE to ST_DONE on start with the end marker set.
- ST_HDR to ST_PAY on a response with a non-zero count.
- ST_HDR to ST_NEXT on a response with a zero count.
- ST_PAY to ST_OUT on a response.
- ST_OUT to ST_PAY when a word is accepted and more words remain.
- ST_OUT to ST_NEXT when the last word is accepted.
- ST_NEXT to ST_DONE on the end marker or on a detected loop.
- ST_NEXT to ST_HDR otherwise.
- ST_DONE to ST_IDLE always.

Top module: `chain_walker`

## Requirements
- R1: After reset the block is idle: busy, done, loop_err, mem_req, pl_valid and progress_valid are 0, and cycle_est is 0.
- R2: On start in idle, start_addr is reduced to its low 24 bits. If bit 23 of that value is set, the walk completes at once with a done pulse, no memory read is issued, and cycle_est is 0.
- R3: A header word holds the payload count in bits 31:24 and the next node address in bits 23:0. Every memory read uses the byte address (node address AND 0x1FFFFC) on mem_addr.
- R4: Payload word i (counting from 1) of a node is read at (header address + 4*i) AND 0x1FFFFC. Payload words are forwarded in order on pl_data. A word offered on pl_valid stays unchanged until pl_ready accepts it.
- R5: After each node, progress_valid pulses for one cycle and progress_addr shows that node's next address.
- R6: When a node's next address has bit 23 set, the walk ends with a one-cycle done pulse, and busy falls after it.
- R7: cycle_est starts at 0 on each start. It adds 10 for every node with a zero count, and 5 plus the count for every other node.
- R8: The loop checkpoint starts as the masked start address. A next address equal to the checkpoint ends the walk with done and sets loop_err. loop_err stays set until the next start.
- R9: When the node count reaches the refresh limit (first 32), the checkpoint takes that node's next address and the limit doubles. A ring that does not include the start node is therefore caught.
- R10: A start pulse while busy is ignored and does not disturb the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| start_addr | input | 32 | First node address; low 24 bits used |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| loop_err | output | 1 | Sticky loop-detected flag |
| mem_req | output | 1 | Memory read request, held until response |
| mem_addr | output | 21 | Word-aligned byte address of the read |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| pl_valid | output | 1 | Payload word offered |
| pl_data | output | 32 | Payload word |
| pl_ready | input | 1 | Framer accepts the payload word |
| progress_valid | output | 1 | Progress address update pulse |
| progress_addr | output | 24 | Next node address of the node just finished |
| cycle_est | output | 32 | Accumulated cost estimate |

## Verification
A corrupted payload index shows up on the first multi-word node, as a wrong mem_addr or a missing or extra pl_data word. A header latched into the wrong field shows up one node later, as a wrong progress_addr and a wrong cost step. A checkpoint or refresh limit that is off appears only after tens of nodes, as a loop caught at the wrong node count or not caught at all. Ring chains are therefore walked long enough to count progress pulses across two refreshes. A stuck state shows up as a missing done pulse within a bounded number of cycles.

// File: rtl/chain_walker_pkg.sv
package chain_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_OUT,
        ST_NEXT,
        ST_DONE
    } walk_state_t;

    // cost of one node: 10 when empty, else 5 plus the payload count
    function automatic logic [15:0] node_cost(input logic [7:0] cnt);
        return (cnt == 8'd0) ? 16'd10 : 16'd5 + {8'd0, cnt};
    endfunction

endpackage

// File: rtl/chain_cost_acc.sv
module chain_cost_acc #(
    parameter int EW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          add_en,
    input  logic [7:0]    cnt,
    output logic [EW-1:0] est
);
    import chain_walker_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      est <= '0;
        else if (clear)  est <= '0;
        else if (add_en) est <= est + EW'(node_cost(cnt));
    end

    assert_cost_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clear) |=> ((est - $past(est)) >= EW'(5)));

endmodule

// File: rtl/chain_loop_guard.sv
module chain_loop_guard #(
    parameter int AW    = 24,
    parameter int NW    = 16,
    parameter int FIRST = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [AW-1:0] init_addr,
    input  logic          step,
    input  logic [AW-1:0] nxt_addr,
    output logic          loop_hit
);
    localparam logic [NW-1:0] LIM0 = NW'(FIRST);

    logic [AW-1:0] ckpt;
    logic [NW-1:0] nodes;
    logic [NW-1:0] limit;

    assign loop_hit = step && (nxt_addr == ckpt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ckpt  <= '0;
            nodes <= '0;
            limit <= LIM0;
        end else if (clear) begin
            ckpt  <= init_addr;
            nodes <= '0;
            limit <= LIM0;
        end else if (step && !loop_hit) begin
            nodes <= nodes + 1'b1;
            if (nodes + 1'b1 == limit) begin
                ckpt  <= nxt_addr;
                limit <= limit << 1;
            end
        end
    end

    assert_limit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(limit));

endmodule

// File: rtl/chain_walker.sv
module chain_walker #(
    parameter int AW     = 24,
    parameter int MAW    = 21,
    parameter int DW     = 32,
    parameter int CW     = 8,
    parameter int EW     = 32,
    parameter int NW     = 16,
    parameter int FIRSTK = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [31:0]    start_addr,
    output logic           busy,
    output logic           done,
    output logic           loop_err,
    output logic           mem_req,
    output logic [MAW-1:0] mem_addr,
    input  logic           mem_rvalid,
    input  logic [DW-1:0]  mem_rdata,
    output logic           pl_valid,
    output logic [DW-1:0]  pl_data,
    input  logic           pl_ready,
    output logic           progress_valid,
    output logic [AW-1:0]  progress_addr,
    output logic [EW-1:0]  cycle_est
);
    import chain_walker_pkg::*;

    localparam int END_BIT = AW - 1;
    localparam logic [MAW-1:0] WMASK = {{(MAW-2){1'b1}}, 2'b00};

    walk_state_t state, nstate;

    logic [AW-1:0] cur_addr, nxt_addr, base_addr, prog_q;
    logic [CW-1:0] cnt_q, idx_q;
    logic [DW-1:0] word_q;
    logic          err_q, pv_q;
    logic          take_start, hdr_rsp, step, loop_hit;

    assign take_start = (state == ST_IDLE) && start;
    assign hdr_rsp    = (state == ST_HDR) && mem_rvalid;
    assign step       = (state == ST_NEXT) && !nxt_addr[END_BIT];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // next state and outputs
    always_comb begin
        nstate   = state;
        mem_req  = 1'b0;
        mem_addr = '0;
        pl_valid = 1'b0;
        done     = 1'b0;
        busy     = (state != ST_IDLE);
        unique case (state)
            ST_IDLE: begin
                if (start) nstate = start_addr[END_BIT] ? ST_DONE : ST_HDR;
            end
            ST_HDR: begin
                mem_req  = 1'b1;
                mem_addr = cur_addr[MAW-1:0] & WMASK;
                if (mem_rvalid)
                    nstate = (mem_rdata[DW-1 -: CW] == '0) ? ST_NEXT : ST_PAY;
            end
            ST_PAY: begin
                mem_req  = 1'b1;
                mem_addr = (base_addr[MAW-1:0] + {MAW'(idx_q) + 1'b1, 2'b00}) & WMASK;
                if (mem_rvalid) nstate = ST_OUT;
            end
            ST_OUT: begin
                pl_valid = 1'b1;
                if (pl_ready) nstate = (idx_q + 1'b1 == cnt_q) ? ST_NEXT : ST_PAY;
            end
            ST_NEXT: begin
                if (nxt_addr[END_BIT] || loop_hit) nstate = ST_DONE;
                else                               nstate = ST_HDR;
            end
            ST_DONE: begin
                done   = 1'b1;
                nstate = ST_IDLE;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            nxt_addr  <= '0;
            base_addr <= '0;
            prog_q    <= '0;
            cnt_q     <= '0;
            idx_q     <= '0;
            word_q    <= '0;
            err_q     <= 1'b0;
            pv_q      <= 1'b0;
        end else begin
            pv_q <= (state == ST_NEXT);
            if (take_start) begin
                cur_addr <= start_addr[AW-1:0];
                err_q    <= 1'b0;
            end
            if (hdr_rsp) begin
                cnt_q     <= mem_rdata[DW-1 -: CW];
                nxt_addr  <= mem_rdata[AW-1:0];
                base_addr <= cur_addr;
                idx_q     <= '0;
            end
            if (state == ST_PAY && mem_rvalid) word_q <= mem_rdata;
            if (state == ST_OUT && pl_ready)   idx_q  <= idx_q + 1'b1;
            if (state == ST_NEXT) begin
                cur_addr <= nxt_addr;
                prog_q   <= nxt_addr;
                if (loop_hit) err_q <= 1'b1;
            end
        end
    end

    assign pl_data        = word_q;
    assign loop_err       = err_q;
    assign progress_valid = pv_q;
    assign progress_addr  = prog_q;

    chain_cost_acc #(.EW(EW)) u_cost (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (take_start),
        .add_en (hdr_rsp),
        .cnt    (mem_rdata[DW-1 -: CW]),
        .est    (cycle_est)
    );

    chain_loop_guard #(.AW(AW), .NW(NW), .FIRST(FIRSTK)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (take_start),
        .init_addr (start_addr[AW-1:0]),
        .step      (step),
        .nxt_addr  (nxt_addr),
        .loop_hit  (loop_hit)
    );

    assert_hold_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && !pl_ready) |=> (pl_valid && $stable(pl_data)));
    assert_end_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (progress_valid && progress_addr[END_BIT]) |-> done);
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_err && !take_start) |=> loop_err);
    assert_err_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loop_err) |-> done);

endmodule

// File: tb/sim_chain_walker.sv
module sim_chain_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        busy, done, loop_err, mem_req, mem_rvalid, pl_valid, pl_ready;
    logic        progress_valid;
    logic [20:0] mem_addr;
    logic [31:0] mem_rdata, pl_data, cycle_est;
    logic [23:0] progress_addr;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] mem [0:4095];
    logic [31:0] got [$];
    int          n_reads, n_prog;
    logic [20:0] first_rd;
    logic [23:0] last_prog;
    bit          rdy_toggle;

    always #10 clk = ~clk;   // 50 MHz

    chain_walker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .busy(busy), .done(done), .loop_err(loop_err),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .pl_valid(pl_valid), .pl_data(pl_data),
        .pl_ready(pl_ready), .progress_valid(progress_valid),
        .progress_addr(progress_addr), .cycle_est(cycle_est)
    );

    // memory model: one response per request, one cycle later
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= mem_req && !mem_rvalid;
            mem_rdata  <= mem[mem_addr[13:2]];
            if (mem_req && !mem_rvalid) begin
                if (n_reads == 0) first_rd <= mem_addr;
                n_reads <= n_reads + 1;
            end
            if (pl_valid && pl_ready) got.push_back(pl_data);
            if (progress_valid) begin
                n_prog    <= n_prog + 1;
                last_prog <= progress_addr;
            end
        end
    end

    always @(negedge clk) pl_ready <= rdy_toggle ? ~pl_ready : 1'b1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic node(input int a, input int cnt, input int nxt);
        mem[a >> 2] = {cnt[7:0], nxt[23:0]};
    endtask

    task automatic go(input logic [31:0] a);
        @(negedge clk);
        got.delete();
        n_reads = 0;
        n_prog  = 0;
        start_addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int k;
        for (k = 0; k < 5000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (k == 5000) chk(1'b0, "watchdog", k, 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !loop_err, "R1 idle flags", {busy, done, loop_err}, 0);
        chk(!mem_req && !pl_valid && !progress_valid, "R1 idle ports",
            {mem_req, pl_valid, progress_valid}, 0);
        chk(cycle_est == 0, "R1 estimate", cycle_est, 0);
    endtask

    task automatic t_end_at_start();
        go(32'h0080_0000);
        wait_done();
        chk(n_reads == 0, "R2 no read on end marker", n_reads, 0);
        chk(cycle_est == 0, "R2 estimate", cycle_est, 0);
        chk(!busy, "R6 idle after done", busy, 0);
    endtask

    task automatic t_chain();
        node(32'h100, 2, 32'h200);
        mem[32'h104 >> 2] = 32'hA1A1_0001;
        mem[32'h108 >> 2] = 32'hA2A2_0002;
        node(32'h200, 0, 32'h300);
        node(32'h300, 1, 32'hFF_FFFF);
        mem[32'h304 >> 2] = 32'hA3A3_0003;
        rdy_toggle = 1'b1;
        go(32'h0000_0100);
        wait_done();
        rdy_toggle = 1'b0;
        chk(got.size() == 3, "R4 payload count", got.size(), 3);
        if (got.size() == 3) begin
            chk(got[0] == 32'hA1A1_0001, "R4 word0", got[0], 32'hA1A1_0001);
            chk(got[1] == 32'hA2A2_0002, "R4 word1", got[1], 32'hA2A2_0002);
            chk(got[2] == 32'hA3A3_0003, "R4 word2", got[2], 32'hA3A3_0003);
        end
        chk(n_reads == 6, "R3 read count", n_reads, 6);
        chk(n_prog == 3, "R5 progress pulses", n_prog, 3);
        chk(last_prog == 24'hFF_FFFF, "R5 last progress", last_prog, 24'hFF_FFFF);
        chk(cycle_est == 23, "R7 estimate mixed", cycle_est, 23);
        chk(!loop_err, "R6 clean end", loop_err, 0);
    endtask

    task automatic t_mask();
        node(32'h10, 1, 32'h80_0000);
        mem[32'h14 >> 2] = 32'hB1B1_0001;
        go(32'h0120_0010);
        wait_done();
        chk(first_rd == 21'h00_0010, "R3 masked header address", first_rd, 21'h10);
        chk(got.size() == 1 && got[0] == 32'hB1B1_0001, "R2 masked walk payload",
            got.size(), 1);
        chk(last_prog == 24'h80_0000, "R6 end progress", last_prog, 24'h80_0000);
        chk(cycle_est == 6, "R7 estimate single", cycle_est, 6);
    endtask

    task automatic t_self_loop();
        node(32'h400, 0, 32'h400);
        go(32'h0000_0400);
        wait_done();
        chk(loop_err, "R8 self loop flagged", loop_err, 1);
        chk(n_prog == 1, "R8 self loop node count", n_prog, 1);
        chk(cycle_est == 10, "R7 estimate empty", cycle_est, 10);
    endtask

    task automatic t_late_loop();
        node(32'h500, 0, 32'h600);
        node(32'h600, 0, 32'h600);
        go(32'h0000_0500);
        repeat (5) @(negedge clk);
        start_addr = 32'h0080_0000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R10 start ignored while busy", busy, 1);
        wait_done();
        chk(loop_err, "R9 loop caught after refresh", loop_err, 1);
        chk(n_prog == 33, "R9 first refresh at 32", n_prog, 33);
        chk(cycle_est == 330, "R10 walk undisturbed", cycle_est, 330);
        @(negedge clk);
        chk(loop_err, "R8 flag sticky", loop_err, 1);
    endtask

    task automatic t_ring();
        node(32'hF00, 0, 32'h1000);
        for (int i = 0; i < 40; i++)
            node(32'h1000 + 4 * i, 0, 32'h1000 + 4 * ((i + 1) % 40));
        go(32'h0000_0F00);
        wait_done();
        chk(loop_err, "R9 ring caught", loop_err, 1);
        chk(n_prog == 104, "R9 doubled interval", n_prog, 104);
        chk(cycle_est == 1040, "R7 ring estimate", cycle_est, 1040);
    endtask

    task automatic t_clear_err();
        go(32'h0000_0300);
        wait_done();
        chk(!loop_err, "R8 flag cleared by start", loop_err, 0);
        chk(cycle_est == 6, "R7 cleared on start", cycle_est, 6);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0080_0000;
        rdy_toggle = 1'b0;
        pl_ready = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_end_at_start();
        t_chain();
        t_mask();
        t_self_loop();
        t_late_loop();
        t_ring();
        t_clear_err();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule